// File: doc/BRIEF.md
# Fixed-Depth Hardware Return Stack

This block keeps subroutine and interrupt return addresses in a small register file next to the processor core, so that data RAM is never used for them. A call or an interrupt entry asserts the push input together with the address to return to. A return asserts the pop input and takes its target from the top-of-stack output in that same cycle. Every operation completes in one clock cycle, so call and return latency never varies.

The stack works straight out of reset. There is no stack pointer for software to set up, and software cannot see one. The depth is a parameter. When the stack is already full, a further push overwrites the oldest return address in circular fashion and does not fault. A sticky overflow flag records that this has happened. A pop on an empty stack still returns a defined value from the register file and raises a sticky underflow flag.

Top module: `ret_stack`

## Requirements
- R1: While rst_ni is low and after its release: empty_o=1, full_o=0, ovf_o=0, unf_o=0, and every entry reads as zero, so top_o=0.
- R2: A push (push_i=1, pop_i=0) stores addr_i. After that clock edge, top_o equals addr_i and empty_o=0.
- R3: A pop (pop_i=1, push_i=0) returns the value on top_o in the same cycle. After the edge, top_o shows the next older entry, so entries come back in last-in first-out order.
- R4: full_o=1 exactly when DEPTH entries are held. empty_o=1 exactly when none are held. The two are never 1 together.
- R5: A push while full writes over the oldest entry. The stack still holds DEPTH entries, and pops return the newest DEPTH addresses in last-in first-out order.
- R6: ovf_o becomes 1 after the first push made while full. It stays at 1 until reset.
- R7: push_i=1 and pop_i=1 together on a non-empty stack replace the top entry with addr_i. The entry count does not change.
- R8: push_i=1 and pop_i=1 together on an empty stack act as a push: one entry is held afterwards, and unf_o does not change.
- R9: A pop on an empty stack sets unf_o, which stays at 1 until reset. empty_o stays 1. The read position steps down one place in the circular file, so after a wrapping overflow that pop returns the most recently wrapped entry.
- R10: With neither push_i nor pop_i asserted, top_o and every flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save addr_i (call or interrupt entry) |
| pop_i | input | 1 | Remove the top entry (return) |
| addr_i | input | AW | Return address to save |
| top_o | output | AW | Current top-of-stack entry |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | DEPTH entries held |
| ovf_o | output | 1 | Sticky: a push has overwritten the oldest entry |
| unf_o | output | 1 | Sticky: a pop was made on an empty stack |

## Verification
The bench builds the stack with DEPTH=5 and AW=12. Five is not a power of two, so the explicit wrap from the last index back to zero is exercised in both directions, which a power-of-two depth would hide behind natural rollover. The small depth lets a short sequence fill the stack, wrap it once, drain it completely and then underflow into the wrapped slot. Combined pushes and pops are exercised on both an empty and a non-empty stack.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } op_e;

  function automatic op_e op_decode(input logic push, input logic pop);
    return op_e'({push, pop});
  endfunction
endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [PW-1:0] wp_q, wp_d, wp_inc, wp_dec;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_d, unf_d;
  logic          is_empty, is_full;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CW'(DEPTH));
  assign wp_inc   = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
  assign wp_dec   = (wp_q == '0) ? PW'(DEPTH - 1) : wp_q - 1'b1;
  assign rd_idx_o = wp_dec;

  always_comb begin
    wp_d     = wp_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_o;
    unf_d    = unf_o;
    wr_en_o  = 1'b0;
    wr_idx_o = wp_q;
    unique case (op_i)
      OP_PUSH: begin
        wr_en_o = 1'b1;
        wp_d    = wp_inc;
        if (is_full) ovf_d = 1'b1;  // oldest entry is lost
        else         cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        wp_d = wp_dec;              // steps even when empty: defined readout
        if (is_empty) unf_d = 1'b1;
        else          cnt_d = cnt_q - 1'b1;
      end
      OP_SWAP: begin
        wr_en_o  = 1'b1;
        wr_idx_o = wp_dec;
        if (is_empty) cnt_d = CW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      ovf_o <= ovf_d;
      unf_o <= unf_d;
    end
  end

  assign empty_o = is_empty;
  assign full_o  = is_full;
endmodule

// File: rtl/ret_stack_regfile.sv
module ret_stack_regfile #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PW'(g))     ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  op_e           op;
  logic          wr_en;
  logic [PW-1:0] wr_idx, rd_idx;

  assign op = op_decode(push_i, pop_i);

  ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .empty_o  (empty_o),
    .full_o   (full_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  ret_stack_regfile #(.DEPTH(DEPTH), .AW(AW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (addr_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (top_o)
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] top_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          unf_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> empty_o && !full_o && !ovf_o && !unf_o); // R1
  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |=> top_o == $past(addr_i) && !empty_o); // R2
  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni) !(empty_o && full_o)); // R4
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && full_o |=> ovf_o && full_o); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |=> ovf_o); // R6
  AST_SWAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i |=> top_o == $past(addr_i) && !empty_o); // R7
  AST_SWAP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty_o |=> $stable(full_o)); // R7
  AST_SWAP_EMPTY_UNF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && empty_o |=> $stable(unf_o)); // R8
  AST_UNF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty_o |=> unf_o && empty_o); // R9
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) unf_o |=> unf_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && !pop_i |=> $stable(top_o) && $stable(empty_o) && $stable(full_o)); // R10
endmodule

bind ret_stack ret_stack_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .addr_i  (addr_i),
  .top_o   (top_o),
  .empty_o (empty_o),
  .full_o  (full_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o)
);

// File: tb/tb_ret_stack.sv
module tb_ret_stack;
  localparam int DEPTH = 5;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] top_o;
  logic          empty_o, full_o, ovf_o, unf_o;
  int            checks = 0, errors = 0;

  ret_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i), .addr_i(addr_i),
    .top_o(top_o), .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample one ns later
  task automatic step(input logic pu, input logic po, input logic [AW-1:0] a);
    @(negedge clk);
    push_i = pu; pop_i = po; addr_i = a;
    @(posedge clk); #1;
    push_i = 1'b0; pop_i = 1'b0; addr_i = '0;
  endtask

  task automatic flags(input string req, input int e, input int f, input int o, input int u);
    chk(req, "empty_o", int'(empty_o), e);
    chk(req, "full_o",  int'(full_o),  f);
    chk(req, "ovf_o",   int'(ovf_o),   o);
    chk(req, "unf_o",   int'(unf_o),   u);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    #1; flags("R1 in reset", 1, 0, 0, 0);
    chk("R1", "top_o in reset", int'(top_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    flags("R1 after reset", 1, 0, 0, 0);
    chk("R1", "top_o after reset", int'(top_o), 0);
  endtask

  task automatic t_push_pop();
    step(1, 0, 12'h111); chk("R2", "top after push1", int'(top_o), 'h111);
    chk("R2", "empty after push", int'(empty_o), 0);
    step(1, 0, 12'h222); chk("R2", "top after push2", int'(top_o), 'h222);
    step(1, 0, 12'h333); chk("R2", "top after push3", int'(top_o), 'h333);
    step(0, 0, '0); step(0, 0, '0);
    chk("R10", "top held idle", int'(top_o), 'h333);
    flags("R10 idle flags", 0, 0, 0, 0);
    chk("R3", "return value pop1", int'(top_o), 'h333);
    step(0, 1, '0); chk("R3", "top after pop1", int'(top_o), 'h222);
    step(0, 1, '0); chk("R3", "top after pop2", int'(top_o), 'h111);
    step(0, 1, '0); flags("R3 R4 drained", 1, 0, 0, 0);
  endtask

  task automatic t_swap();
    step(1, 0, 12'h0A0); step(1, 0, 12'h0B0);
    step(1, 1, 12'h0C0); chk("R7", "top after swap", int'(top_o), 'h0C0);
    step(0, 1, '0); chk("R7", "entry below swap", int'(top_o), 'h0A0);
    chk("R7", "one entry left", int'(empty_o), 0);
    step(0, 1, '0); flags("R7 drained", 1, 0, 0, 0);
  endtask

  task automatic t_swap_empty();
    step(1, 1, 12'h0D0);
    chk("R8", "top after empty swap", int'(top_o), 'h0D0);
    flags("R8 one held", 0, 0, 0, 0);
    step(0, 1, '0); flags("R8 single pop empties", 1, 0, 0, 0);
  endtask

  task automatic t_fill_wrap();
    for (int i = 1; i <= DEPTH; i++) step(1, 0, AW'(12'h100 + i));
    flags("R4 full", 0, 1, 0, 0);
    chk("R4", "top when full", int'(top_o), 'h105);
    step(1, 0, 12'h106);
    flags("R5 R6 wrap", 0, 1, 1, 0);
    chk("R5", "top after wrap", int'(top_o), 'h106);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5", "pop order after wrap", int'(top_o), 'h106 - i);
      step(0, 1, '0);
    end
    flags("R5 R6 drained, ovf kept", 1, 0, 1, 0);
  endtask

  task automatic t_underflow();
    chk("R9", "value returned by empty pop", int'(top_o), 'h106);
    step(0, 1, '0);
    flags("R9 underflow", 1, 0, 1, 1);
    step(1, 0, 12'h1AB);
    chk("R9", "top after push", int'(top_o), 'h1AB);
    flags("R9 unf sticky", 0, 0, 1, 1);
  endtask

  initial begin
    do_reset();
    t_push_pop();
    t_swap();
    t_swap_empty();
    t_fill_wrap();
    t_underflow();
    do_reset();  // R1: flags cleared again
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule